// File: doc/BRIEF.md
# Four-Operation Integer ALU with Condition Flags

This block is the arithmetic unit of a single-cycle 32-bit core. It has no clock and holds no state. Two operands and a two-bit operation code go in. A result and four condition flags come out in the same time step. The decoder uses it for several jobs: register and immediate data-processing operations, adding or subtracting a load/store offset, adding a branch offset to the program counter, and moves. For a move, the ALU passes the second operand through unchanged.

The flags are negative (N), zero (Z), carry (C) and overflow (V). They are given both as a packed four-bit bus and as four separate bits. On subtraction, the carry flag means "no borrow occurred". Storing the flags is done by a status register outside this block.

Top module: `alu_core`

## Requirements
- R1: Operation code 2'b00 gives result = (A + B) modulo 2^32.
- R2: Operation code 2'b01 gives result = (A - B) modulo 2^32.
- R3: Operation code 2'b10 gives result = the low 32 bits of the unsigned product A * B.
- R4: Operation code 2'b11 gives result = B, whatever the value of A.
- R5: N equals bit 31 of the result, for every operation.
- R6: Z is 1 exactly when all 32 result bits are zero, for every operation.
- R7: C is the carry out of bit 31 for addition. For subtraction, C is 1 exactly when A >= B as unsigned numbers. C is 0 for multiply and move.
- R8: V shows signed overflow. For addition, V is 1 when A and B have the same sign and the result sign differs from it. For subtraction, V is 1 when A and B differ in sign and the result sign differs from A's sign. V is 0 for multiply and move.
- R9: The flag bus carries the flags in this bit order: bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. Each bus bit equals the matching single-bit output.
- R10: The block is purely combinational. A change of inputs shows on every output without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand (A) |
| opb_i | input | 32 | Second operand (B), also the value passed through by move |
| op_i | input | 2 | Operation select: 00 add, 01 subtract, 10 multiply, 11 move |
| result_o | output | 32 | Operation result |
| flags_o | output | 4 | Packed flags {N, Z, C, V} |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry / no-borrow flag |
| v_o | output | 1 | Signed overflow flag |

## Verification
The assertions run whenever the inputs are known. They check these rules on every input change:
- the move operation passes B through;
- the zero flag tracks the result;
- carry on subtraction matches the unsigned comparison;
- carry and overflow are both clear for multiply and move;
- the result of add and subtract agrees with the arithmetic.

Some things only the bench scenarios can show. These include exact overflow and carry at the signed and unsigned boundaries (0x7FFFFFFF+1, 0x80000000-1, 0-0, 0xFFFFFFFF+1). They also include multiply wrap-around to zero, the bit order of the flag bus, and an output that follows an input change without any clock edge.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_MOV = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide_sum;

    // Subtraction is A + ~B + 1; the carry out then means "no borrow".
    always_comb begin
        b_eff    = sub_i ? ~b_i : b_i;
        wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
        sum_o    = wide_sum[MSB:0];
        carry_o  = wide_sum[WIDTH];
        ovf_o    = (a_i[MSB] == b_eff[MSB]) && (wide_sum[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] prod_o
);
    // Only the low WIDTH bits of the product are kept.
    always_comb begin
        prod_o = a_i * b_i;
    end
endmodule

// File: rtl/alu_nz.sv
module alu_nz #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res_i,
    output logic             neg_o,
    output logic             zero_o
);
    always_comb begin
        neg_o  = res_i[WIDTH-1];
        zero_o = ~|res_i;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic [3:0]       flags_o,
    output logic             n_o,
    output logic             z_o,
    output logic             c_o,
    output logic             v_o
);
    alu_op_e          op;
    logic [WIDTH-1:0] as_sum;
    logic             as_carry;
    logic             as_ovf;
    logic [WIDTH-1:0] mul_prod;
    logic             nz_neg;
    logic             nz_zero;
    alu_flags_t       flags;

    assign op = alu_op_e'(op_i);

    alu_addsub #(.WIDTH(WIDTH)) addsub_i (
        .a_i     (opa_i),
        .b_i     (opb_i),
        .sub_i   (op == OP_SUB),
        .sum_o   (as_sum),
        .carry_o (as_carry),
        .ovf_o   (as_ovf)
    );

    alu_mul #(.WIDTH(WIDTH)) mul_i (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .prod_o (mul_prod)
    );

    // Result select: the spare code implements move.
    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: result_o = as_sum;
            OP_MUL:         result_o = mul_prod;
            OP_MOV:         result_o = opb_i;
            default:        result_o = '0;
        endcase
    end

    alu_nz #(.WIDTH(WIDTH)) nz_i (
        .res_i  (result_o),
        .neg_o  (nz_neg),
        .zero_o (nz_zero)
    );

    // Flag assembly: C and V only carry meaning for add and subtract.
    always_comb begin
        flags.n = nz_neg;
        flags.z = nz_zero;
        unique case (op)
            OP_ADD, OP_SUB: begin
                flags.c = as_carry;
                flags.v = as_ovf;
            end
            default: begin
                flags.c = 1'b0;
                flags.v = 1'b0;
            end
        endcase
    end

    assign flags_o = flags;
    assign n_o     = flags.n;
    assign z_o     = flags.z;
    assign c_o     = flags.c;
    assign v_o     = flags.v;

    // Combinational checks, evaluated whenever every input is known.
    always_comb begin
        if (!$isunknown({opa_i, opb_i, op_i})) begin
            // R4
            move_pass_chk: assert (op != OP_MOV || result_o == opb_i)
                else $error("move did not pass B");
            // R6
            zero_flag_chk: assert (z_o == (result_o == '0))
                else $error("zero flag disagrees with result");
            // R7
            sub_carry_chk: assert (op != OP_SUB || c_o == (opa_i >= opb_i))
                else $error("subtract carry is not no-borrow");
            // R8
            no_overflow_chk: assert (!(op == OP_MUL || op == OP_MOV) || (!v_o && !c_o))
                else $error("C or V set for multiply/move");
            // R1
            add_result_chk: assert (op != OP_ADD || result_o - opb_i == opa_i)
                else $error("add result wrong");
            // R2
            sub_result_chk: assert (op != OP_SUB || result_o + opb_i == opa_i)
                else $error("subtract result wrong");
        end
    end
endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb_top;
    logic        clk = 1'b0;
    logic [31:0] a, b;
    logic [1:0]  op;
    logic [31:0] res;
    logic [3:0]  flg;
    logic        n, z, c, v;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    alu_core dut_i (
        .opa_i(a), .opb_i(b), .op_i(op),
        .result_o(res), .flags_o(flg),
        .n_o(n), .z_o(z), .c_o(c), .v_o(v)
    );

    // Vector: {A, B, op, expected result, expected flags NZCV}
    localparam int NV = 13;
    localparam logic [101:0] VEC [NV] = '{
        {32'h00000001, 32'h00000002, 2'b00, 32'h00000003, 4'b0000}, // R1
        {32'h7FFFFFFF, 32'h00000001, 2'b00, 32'h80000000, 4'b1001}, // R8
        {32'hFFFFFFFF, 32'h00000001, 2'b00, 32'h00000000, 4'b0110}, // R7
        {32'h00000005, 32'h00000003, 2'b01, 32'h00000002, 4'b0010}, // R2
        {32'h00000003, 32'h00000005, 2'b01, 32'hFFFFFFFE, 4'b1000}, // R7
        {32'h80000000, 32'h00000001, 2'b01, 32'h7FFFFFFF, 4'b0011}, // R8
        {32'h00000000, 32'h00000000, 2'b01, 32'h00000000, 4'b0110}, // R6
        {32'h7FFFFFFF, 32'hFFFFFFFF, 2'b01, 32'h80000000, 4'b1001}, // R8
        {32'h00010000, 32'h00010000, 2'b10, 32'h00000000, 4'b0100}, // R3
        {32'h00000003, 32'hFFFFFFFE, 2'b10, 32'hFFFFFFFA, 4'b1000}, // R3
        {32'h12345678, 32'h00000000, 2'b11, 32'h00000000, 4'b0100}, // R4
        {32'hFFFFFFFF, 32'h80000000, 2'b11, 32'h80000000, 4'b1000}, // R5
        {32'hDEADBEEF, 32'h0000002A, 2'b11, 32'h0000002A, 4'b0000}  // R4
    };

    function automatic logic [35:0] model(input logic [31:0] x, input logic [31:0] y,
                                          input logic [1:0] o);
        logic [32:0] w;
        logic [31:0] r;
        logic        cc, vv;
        cc = 0; vv = 0;
        case (o)
            2'b00: begin
                w = {1'b0, x} + {1'b0, y}; r = w[31:0]; cc = w[32];
                vv = ($signed(x) + $signed(y)) !== $signed({{1{x[31]}}, x} + {{1{y[31]}}, y});
                vv = (x[31] == y[31]) && (r[31] != x[31]);
            end
            2'b01: begin
                r = x - y; cc = (x >= y);
                vv = (x[31] != y[31]) && (r[31] != x[31]);
            end
            2'b10: r = x * y;
            default: r = y;
        endcase
        return {r, r[31], (r == 32'd0), cc, vv};
    endfunction

    task automatic check(input string req, input logic [31:0] er, input logic [3:0] ef);
        checks++;
        if (res !== er || flg !== ef || {n, z, c, v} !== ef) begin
            errors++;
            $display("FAIL %s: A=%h B=%h op=%b got res=%h flags=%b bits=%b%b%b%b, exp res=%h flags=%b",
                     req, a, b, op, res, flg, n, z, c, v, er, ef);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #4_000_000;
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, exp completion");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr_a, lfsr_b;
        logic [35:0] m;
        a = '0; b = '0; op = 2'b00;
        @(negedge clk); #2;
        check("R6 idle-zero state", 32'd0, 4'b0100);

        // R1 R2 R3 R4 R5 R6 R7 R8 R9: table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {a, b, op} = VEC[i][101:36];
            #2;
            check("R1-table vector", VEC[i][35:4], VEC[i][3:0]);
        end

        // R9: pseudo-random vectors against the model, every op
        lfsr_a = 32'hACE1_1234; lfsr_b = 32'h0BAD_F00D;
        for (int i = 0; i < 200; i++) begin
            lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
            lfsr_b = {lfsr_b[30:0], lfsr_b[31] ^ lfsr_b[21] ^ lfsr_b[1] ^ lfsr_b[0]};
            @(negedge clk);
            a = lfsr_a; b = (i % 7 == 0) ? lfsr_a : lfsr_b; op = 2'(i % 4);
            #2;
            m = model(a, b, op);
            check("R9 model compare", m[35:4], m[3:0]);
        end

        // R10: change inputs between edges, outputs follow with no clock
        @(posedge clk); #3;
        a = 32'd40; b = 32'd2; op = 2'b00; #1;
        check("R10 no-clock add", 32'd42, 4'b0000);
        op = 2'b01; #1;
        check("R10 no-clock sub", 32'd38, 4'b0010);
        op = 2'b10; #1;
        check("R10 no-clock mul", 32'd80, 4'b0000);
        finish_run();
    end
endmodule